// File: doc/BRIEF.md
# Display Memory Host Address Generator

This block turns host-side display commands into addresses for the pixel memory of a small dot-matrix panel driver. It holds a page register and a column counter. The host loads each one with its own strobe. Every read or write strobe then produces one registered memory request, carrying the current page and column. The column counter moves forward by one after each request, so a host can stream a row of bytes without setting the column again.

The column counter reacts to a column value beyond the panel's last column by freezing. Requests from a frozen counter never reach memory. The only way to release the freeze is to set a new column. The page register never changes because of column activity. A segment-reverse control mirrors the column the memory sees. One page above the pixel pages is an indicator row, and the block restricts writes to that row to a single data bit through a byte mask.

Top module: `hra_top`

## Requirements
- R1: A read or write strobe makes a request at the current (pre-increment) column, and the column counter then advances by one, so back-to-back requests use consecutive columns.
- R2: Setting a column value above 79 (0x50 or more) locks the counter: later strobes give no request (mem_en stays 0) and do not move the counter.
- R3: A column set clears the lock when the new value is 79 or below, and requests resume at exactly that column.
- R4: The page register loads only on the set-page strobe. Column increments, reaching the last column, and locking never change it.
- R5: With seg_reverse high, the column on mem_col is 79 minus the logical column. With seg_reverse low, it equals the logical column.
- R6: Pages 0 to 3 give mem_mask 0xFF. Page 4 (the indicator row) gives mem_mask 0x01, so only data bit 0 is valid there.
- R7: A page value above 4 gives no request, but the column counter still advances on each strobe.
- R8: wr_stb gives mem_en=1 and mem_we=1. rd_stb alone gives mem_en=1 and mem_we=0. Both pulse for one cycle, registered on the clock edge that samples the strobe.
- R9: After a synchronous reset, the page and column are 0, the counter is unlocked, mem_en and mem_we are 0, and mem_mask is 0x00.
- R10: A request at column 79 advances the counter to 80 and locks it, so the next strobe gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_page_stb | input | 1 | Load page_val into the page register |
| page_val | input | 4 | New page value |
| set_col_stb | input | 1 | Load col_val into the column counter; has priority over increment |
| col_val | input | 7 | New column value |
| rd_stb | input | 1 | Display data read strobe |
| wr_stb | input | 1 | Display data write strobe |
| seg_reverse | input | 1 | Mirror the column mapping when high |
| mem_en | output | 1 | Registered memory request valid |
| mem_we | output | 1 | Registered write enable |
| mem_page | output | 4 | Registered page address |
| mem_col | output | 7 | Registered physical column address |
| mem_mask | output | 8 | Registered data-bit write mask |

## Verification
The hardest state to reach is a lock that comes from the counter running off the last column rather than from a direct out-of-range set. This lock is invisible at the ports except as missing requests. The stimulus sets column 79, issues one request that must succeed, and then confirms that further strobes are silent. A page change does not release the lock, but a fresh in-range column set restarts requests at the chosen column. A similar sequence on an out-of-range page proves that the counter keeps moving while no request is made: the bench strobes on page 6, then switches to a valid page and reads the advanced column.

// File: rtl/hra_pkg.sv
package hra_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/hra_col_ctr.sv
module hra_col_ctr #(
  parameter int COL_W    = 7,
  parameter int LAST_COL = 79
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic [COL_W-1:0] set_val,
  input  logic             acc,
  output logic [COL_W-1:0] col,
  output logic             locked
);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      locked <= 1'b0;
    end else if (set_stb) begin
      col    <= set_val;
      locked <= (set_val > LAST_C);
    end else if (acc && !locked) begin
      col <= col + 1'b1;
      if (col == LAST_C) locked <= 1'b1;
    end
  end

  // R2: a locked counter holds its value until a new column is set
  a_r2_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (locked && !set_stb) |=> ($stable(col) && locked));

  // R3: a column set loads the value and decides the lock from it
  a_r3_set_loads: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> (col == $past(set_val) && locked == ($past(set_val) > LAST_C)));

  // R1: an access on an unlocked counter advances it by one
  a_r1_increment: assert property (@(posedge clk) disable iff (rst)
    (acc && !locked && !set_stb) |=> (col == COL_W'($past(col) + 1'b1)));
endmodule

// File: rtl/hra_page_reg.sv
module hra_page_reg #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [PAGE_W-1:0] set_val,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)          page <= '0;
    else if (set_stb) page <= set_val;
  end

  // R4: nothing but the set strobe moves the page
  a_r4_page_stable: assert property (@(posedge clk) disable iff (rst)
    !set_stb |=> $stable(page));
endmodule

// File: rtl/hra_map.sv
module hra_map
  import hra_pkg::*;
#(
  parameter int COL_W       = 7,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int LAST_COL    = 79,
  parameter int IND_PAGE    = 4,
  parameter bit REV_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_e         kind,
  input  logic [COL_W-1:0]  col,
  input  logic              locked,
  input  logic [PAGE_W-1:0] page,
  input  logic              reverse,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_mask
);
  localparam logic [COL_W-1:0]  LAST_C = COL_W'(LAST_COL);
  localparam logic [PAGE_W-1:0] IND_P  = PAGE_W'(IND_PAGE);
  localparam logic [DATA_W-1:0] M_IND  = DATA_W'(1);
  localparam logic [DATA_W-1:0] M_FULL = '1;

  logic             addr_ok;
  logic [COL_W-1:0] phys_col;

  assign addr_ok = !locked && (col <= LAST_C) && (page <= IND_P);

  generate
    if (REV_SUPPORT) begin : g_rev
      assign phys_col = reverse ? (LAST_C - col) : col;
    end else begin : g_fwd
      logic unused_rev;
      assign unused_rev = reverse;
      assign phys_col   = col;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      mem_page <= '0;
      mem_col  <= '0;
      mem_mask <= '0;
    end else begin
      mem_en <= (kind != ACC_NONE) && addr_ok;
      mem_we <= (kind == ACC_WR) && addr_ok;
      if ((kind != ACC_NONE) && addr_ok) begin
        mem_page <= page;
        mem_col  <= phys_col;
        mem_mask <= (page == IND_P) ? M_IND : M_FULL;
      end
    end
  end

  // R8: a write is always a request
  a_r8_we_implies_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  // R6: mask takes one of the two legal forms and follows the page
  a_r6_mask_form: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ((mem_page == IND_P) ? (mem_mask == M_IND) : (mem_mask == M_FULL)));

  // R2 / R7: requests only leave with legal addresses
  a_r7_legal_addr: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_col <= LAST_C && mem_page <= IND_P));

  // R2: a locked counter never produces a request
  a_r2_no_req_locked: assert property (@(posedge clk) disable iff (rst)
    locked |=> !mem_en);
endmodule

// File: rtl/hra_top.sv
module hra_top
  import hra_pkg::*;
#(
  parameter int COL_W    = 7,
  parameter int PAGE_W   = 4,
  parameter int DATA_W   = 8,
  parameter int LAST_COL = 79,
  parameter int IND_PAGE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_page_stb,
  input  logic [PAGE_W-1:0] page_val,
  input  logic              set_col_stb,
  input  logic [COL_W-1:0]  col_val,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              seg_reverse,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_mask
);
  acc_kind_e         kind;
  logic [COL_W-1:0]  col;
  logic              locked;
  logic [PAGE_W-1:0] page;

  always_comb begin
    if (wr_stb)      kind = ACC_WR;
    else if (rd_stb) kind = ACC_RD;
    else             kind = ACC_NONE;
  end

  hra_col_ctr #(.COL_W(COL_W), .LAST_COL(LAST_COL)) u_col (
    .clk(clk), .rst(rst), .set_stb(set_col_stb), .set_val(col_val),
    .acc(kind != ACC_NONE), .col(col), .locked(locked)
  );

  hra_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .set_stb(set_page_stb), .set_val(page_val),
    .page(page)
  );

  hra_map #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .LAST_COL(LAST_COL), .IND_PAGE(IND_PAGE), .REV_SUPPORT(1'b1)
  ) u_map (
    .clk(clk), .rst(rst), .kind(kind), .col(col), .locked(locked),
    .page(page), .reverse(seg_reverse),
    .mem_en(mem_en), .mem_we(mem_we), .mem_page(mem_page),
    .mem_col(mem_col), .mem_mask(mem_mask)
  );
endmodule

// File: tb/sim_hra_top.sv
`timescale 1ns/1ps
module sim_hra_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_page_stb = 1'b0;
  logic [3:0] page_val = '0;
  logic       set_col_stb = 1'b0;
  logic [6:0] col_val = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       seg_reverse = 1'b0;
  logic       mem_en, mem_we;
  logic [3:0] mem_page;
  logic [6:0] mem_col;
  logic [7:0] mem_mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hra_top u0 (
    .clk(clk), .rst(rst), .set_page_stb(set_page_stb), .page_val(page_val),
    .set_col_stb(set_col_stb), .col_val(col_val), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .seg_reverse(seg_reverse), .mem_en(mem_en),
    .mem_we(mem_we), .mem_page(mem_page), .mem_col(mem_col), .mem_mask(mem_mask)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_page(int v);
    @(negedge clk); set_page_stb = 1'b1; page_val = 4'(v);
    @(negedge clk); set_page_stb = 1'b0;
  endtask

  task automatic set_col(int v);
    @(negedge clk); set_col_stb = 1'b1; col_val = 7'(v);
    @(negedge clk); set_col_stb = 1'b0;
  endtask

  // one strobe; outputs are sampled at the following negedge
  task automatic access(bit wr);
    @(negedge clk); wr_stb = wr; rd_stb = !wr;
    @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    check("R9", "mem_en", mem_en, 0);
    check("R9", "mem_we", mem_we, 0);
    check("R9", "mem_mask", mem_mask, 0);
    access(1'b1);
    check("R9", "page after reset", mem_page, 0);
    check("R9", "col after reset", mem_col, 0);
  endtask

  task automatic t_stream;
    set_page(1); set_col(5);
    access(1'b1);
    check("R8", "write en", mem_en, 1);
    check("R8", "write we", mem_we, 1);
    check("R1", "first col", mem_col, 5);
    check("R6", "mask page1", mem_mask, 8'hFF);
    access(1'b0);
    check("R1", "second col", mem_col, 6);
    check("R8", "read we", mem_we, 0);
    check("R8", "read en", mem_en, 1);
    @(negedge clk);
    check("R8", "en one cycle", mem_en, 0);
  endtask

  task automatic t_reverse;
    seg_reverse = 1'b1;
    set_col(6); access(1'b1);
    check("R5", "mirrored col 6", mem_col, 73);
    set_col(0); access(1'b1);
    check("R5", "mirrored col 0", mem_col, 79);
    seg_reverse = 1'b0;
    access(1'b1);
    check("R5", "forward col 1", mem_col, 1);
  endtask

  task automatic t_indicator;
    set_page(4); set_col(20); access(1'b1);
    check("R6", "indicator en", mem_en, 1);
    check("R6", "indicator mask", mem_mask, 8'h01);
    check("R6", "indicator page", mem_page, 4);
    set_page(3); access(1'b1);
    check("R6", "page3 mask", mem_mask, 8'hFF);
    check("R1", "col kept over page change", mem_col, 21);
  endtask

  task automatic t_bad_page;
    set_page(6); set_col(3);
    access(1'b1);
    check("R7", "page6 no en", mem_en, 0);
    access(1'b1);
    set_page(0); access(1'b1);
    check("R7", "col advanced while page bad", mem_col, 5);
  endtask

  task automatic t_lock;
    set_page(2); set_col(85);
    access(1'b1);
    check("R2", "locked no en", mem_en, 0);
    access(1'b1); access(1'b0);
    check("R2", "still no en", mem_en, 0);
    set_col(80); access(1'b1);
    check("R2", "0x50 locks", mem_en, 0);
    set_col(10); access(1'b1);
    check("R3", "unlock en", mem_en, 1);
    check("R3", "unlock col", mem_col, 10);
  endtask

  task automatic t_end_of_page;
    set_page(1); set_col(79);
    access(1'b1);
    check("R10", "last col en", mem_en, 1);
    check("R10", "last col", mem_col, 79);
    check("R4", "page at end", mem_page, 1);
    access(1'b1);
    check("R10", "past last no en", mem_en, 0);
    set_page(2); access(1'b1);
    check("R10", "page change keeps lock", mem_en, 0);
    set_col(40); access(1'b1);
    check("R4", "page not moved by wrap", mem_page, 2);
    check("R3", "col after relock set", mem_col, 40);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_stream;
        t_reverse;
        t_indicator;
        t_bad_page;
        t_lock;
        t_end_of_page;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule